// File: doc/BRIEF.md
# Frame Reference Aging Tracker

This block keeps a recency history for every physical page frame so that a memory manager can choose a frame to evict that has gone unused the longest. Each frame owns a single reference flag and a short age register. The access path raises a frame's flag whenever that frame is touched. A periodic aging pulse shifts every age register one place toward the least significant end, copies the frame's flag into the top bit, and then lowers all flags. A frame with a larger age value was therefore touched more recently. A frame with a smaller age value has been idle longer.

A control port lets management code read any frame's flag and lower it. On request, a victim search walks the age registers one frame per cycle. It reports the frame holding the smallest age together with that age value. When several frames share the smallest value, the lowest-numbered one wins. The source of the aging pulse and the eviction work that follows a search are handled outside this block.

Top module: `frame_age_tracker`

## Requirements
- R1: While `rst_n` is low, every reference flag and every age register becomes zero, `scan_busy` and `scan_done` are low, and `victim_frame` and `victim_age` are zero.
- R2: A cycle with `ref_valid` high sets the flag of frame `ref_frame` at that clock edge. No other frame's flag changes.
- R3: `rd_bit` shows the current flag of frame `rd_frame` without a clock delay. A cycle with `clr_valid` high lowers the flag of frame `clr_frame`. When a reference and a clear name the same frame in the same cycle, the flag ends up set.
- R4: On a cycle with `age_tick` high, each frame's age register is replaced by its old value shifted right by one place, with that frame's flag (its value before the edge) placed in the top bit.
- R5: An aging cycle lowers every flag. A reference in the same cycle is kept: that frame's flag is set after the edge, and its age still takes the old flag value. A clear in the same cycle still lets the age take the old flag value.
- R6: `scan_start` sampled while idle begins a search. `scan_busy` is high while the search inspects one frame per cycle. `scan_done` is a single-cycle pulse seen FRAMES+1 clock edges after the start edge, in the same cycle that `scan_busy` falls.
- R7: When `scan_done` rises, `victim_frame` names the frame with the smallest age value, using the lowest index to break ties, and `victim_age` holds that value. Both outputs keep their values until the next `scan_done`.
- R8: `scan_start` sampled while a search is running is ignored. It neither restarts nor lengthens the search, and no second search follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Access to a frame this cycle |
| ref_frame | input | IDX_W | Frame being accessed |
| age_tick | input | 1 | Periodic aging pulse |
| clr_valid | input | 1 | Control request to lower one flag |
| clr_frame | input | IDX_W | Frame whose flag is lowered |
| rd_frame | input | IDX_W | Frame whose flag is read |
| rd_bit | output | 1 | Flag of `rd_frame` |
| scan_start | input | 1 | Request a victim search |
| scan_busy | output | 1 | Search in progress |
| scan_done | output | 1 | One-cycle pulse when search results are valid |
| victim_frame | output | IDX_W | Frame with the smallest age |
| victim_age | output | AGE_W | Age value of `victim_frame` |

## Verification
The bench builds the tracker with FRAMES=4 and AGE_W=3. With only three age bits, a reference moves out of the register after three aging pulses, so a short stimulus sequence reaches both saturated and fully decayed values. This also produces ties at zero, so the lowest-index rule is exercised. With four frames, each search takes five cycles, which makes it practical to check the search length exactly and to send a second start request partway through a search.

// File: rtl/frame_age_tracker.sv
module frame_age_tracker #(
  parameter int FRAMES = 16,
  parameter int AGE_W  = 8,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             age_tick,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_frame,
  input  logic [IDX_W-1:0] rd_frame,
  output logic             rd_bit,
  input  logic             scan_start,
  output logic             scan_busy,
  output logic             scan_done,
  output logic [IDX_W-1:0] victim_frame,
  output logic [AGE_W-1:0] victim_age
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [FRAMES-1:0] ref_bits;
  logic [AGE_W-1:0]  ages [FRAMES];

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic hit_ref, hit_clr;
    assign hit_ref = ref_valid && (ref_frame == IDX_W'(g));
    assign hit_clr = clr_valid && (clr_frame == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)                   ref_bits[g] <= 1'b0;
      else if (hit_ref)             ref_bits[g] <= 1'b1;
      else if (age_tick || hit_clr) ref_bits[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        ages[g] <= '0;
      else if (age_tick) ages[g] <= {ref_bits[g], ages[g][AGE_W-1:1]};
    end
  end

  assign rd_bit = ref_bits[rd_frame];

  logic [IDX_W-1:0] scan_idx, best_idx, nxt_idx;
  logic [AGE_W-1:0] best_age, nxt_age, cur_age;
  logic             take, last;

  assign cur_age = ages[scan_idx];
  assign take    = cur_age < best_age;
  assign nxt_idx = take ? scan_idx : best_idx;
  assign nxt_age = take ? cur_age  : best_age;
  assign last    = scan_idx == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_busy    <= 1'b0;
      scan_done    <= 1'b0;
      scan_idx     <= '0;
      best_idx     <= '0;
      best_age     <= '0;
      victim_frame <= '0;
      victim_age   <= '0;
    end else begin
      scan_done <= 1'b0;
      if (!scan_busy) begin
        if (scan_start) begin
          scan_busy <= 1'b1;
          scan_idx  <= '0;
          best_idx  <= '0;
          best_age  <= '1;
        end
      end else begin
        best_idx <= nxt_idx;
        best_age <= nxt_age;
        scan_idx <= scan_idx + 1'b1;
        if (last) begin
          scan_busy    <= 1'b0;
          scan_done    <= 1'b1;
          victim_frame <= nxt_idx;
          victim_age   <= nxt_age;
        end
      end
    end
  end
endmodule

// File: rtl/frame_age_tracker_chk.sv
module frame_age_tracker_chk #(
  parameter int FRAMES = 16,
  parameter int AGE_W  = 8,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_valid,
  input logic [IDX_W-1:0] ref_frame,
  input logic             age_tick,
  input logic             scan_busy,
  input logic             scan_done,
  input logic [IDX_W-1:0] victim_frame,
  input logic [AGE_W-1:0] victim_age,
  input logic [FRAMES-1:0] ref_bits,
  input logic [AGE_W-1:0] age0
);
  p_ref_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && (int'(ref_frame) < FRAMES) |=> ref_bits[$past(ref_frame)]);

  p_tick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    age_tick && !ref_valid |=> ref_bits == '0);

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    age_tick |=> age0[AGE_W-2:0] == $past(age0[AGE_W-1:1]));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_busy) |-> scan_done);

  p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |-> $stable(victim_frame) && $stable(victim_age));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |=> scan_busy || scan_done);
endmodule

bind frame_age_tracker frame_age_tracker_chk #(.FRAMES(FRAMES), .AGE_W(AGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
  .age_tick(age_tick), .scan_busy(scan_busy), .scan_done(scan_done),
  .victim_frame(victim_frame), .victim_age(victim_age),
  .ref_bits(ref_bits), .age0(ages[0])
);

// File: tb/frame_age_tracker_tb_top.sv
module frame_age_tracker_tb_top;
  localparam int F = 4;
  localparam int W = 3;

  logic clk = 0, rst_n = 0;
  logic ref_valid = 0, age_tick = 0, clr_valid = 0, scan_start = 0;
  logic [1:0] ref_frame = 0, clr_frame = 0, rd_frame = 0;
  logic rd_bit, scan_busy, scan_done;
  logic [1:0] victim_frame;
  logic [W-1:0] victim_age;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_age_tracker #(.FRAMES(F), .AGE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .age_tick(age_tick), .clr_valid(clr_valid), .clr_frame(clr_frame),
    .rd_frame(rd_frame), .rd_bit(rd_bit), .scan_start(scan_start),
    .scan_busy(scan_busy), .scan_done(scan_done),
    .victim_frame(victim_frame), .victim_age(victim_age));

  // fields: [8:5] frames referenced before the tick, [4:3] expected victim, [2:0] expected age
  localparam logic [8:0] VEC [8] = '{
    {4'b0111, 2'd3, 3'd0}, {4'b1000, 2'd0, 3'd2}, {4'b1001, 2'd1, 3'd1},
    {4'b0010, 2'd2, 3'd0}, {4'b0000, 2'd2, 3'd0}, {4'b0100, 2'd0, 3'd0},
    {4'b0001, 2'd1, 3'd0}, {4'b1111, 2'd1, 3'd4}};

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_ref(int f);
    ref_valid = 1; ref_frame = 2'(f); cyc(); ref_valid = 0;
  endtask

  task automatic do_tick();
    age_tick = 1; cyc(); age_tick = 0;
  endtask

  task automatic do_clr(int f);
    clr_valid = 1; clr_frame = 2'(f); cyc(); clr_valid = 0;
  endtask

  function automatic int bit_of(int f);
    rd_frame = 2'(f);
    return 0;
  endfunction

  task automatic read_bit(int f, output int b);
    rd_frame = 2'(f); #1; b = int'(rd_bit);
  endtask

  task automatic run_scan(output int cycles);
    scan_start = 1; cyc(); scan_start = 0; cycles = 1;
    while (!scan_done && cycles < 50) begin cyc(); cycles++; end
  endtask

  task automatic scan_expect(string req, int vf, int va);
    int c;
    run_scan(c);
    chk({req, " scan length"}, c, F + 1);
    chk({req, " victim frame"}, int'(victim_frame), vf);
    chk({req, " victim age"}, int'(victim_age), va);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int b, c;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 busy", int'(scan_busy), 0);
    chk("R1 done", int'(scan_done), 0);
    chk("R1 victim frame", int'(victim_frame), 0);
    chk("R1 victim age", int'(victim_age), 0);
    rst_n = 1; cyc();
    for (int f = 0; f < F; f++) begin read_bit(f, b); chk("R1 flag", b, 0); end
    scan_expect("R1 R6 R7 zero ages", 0, 0);

    // R2 reference sets only its own flag
    do_ref(2);
    read_bit(2, b); chk("R2 set", b, 1);
    read_bit(1, b); chk("R2 other untouched", b, 0);
    // R3 clear and read
    do_ref(1);
    do_clr(2);
    read_bit(2, b); chk("R3 cleared", b, 0);
    read_bit(1, b); chk("R3 neighbour kept", b, 1);
    ref_valid = 1; ref_frame = 0; clr_valid = 1; clr_frame = 0; cyc();
    ref_valid = 0; clr_valid = 0;
    read_bit(0, b); chk("R3 ref beats clear", b, 1);
    do_clr(0); do_clr(1);
    for (int f = 0; f < F; f++) begin read_bit(f, b); chk("R3 all clear", b, 0); end

    // R4 R5 R7 vector walk
    for (int i = 0; i < 8; i++) begin
      for (int f = 0; f < F; f++) if (VEC[i][5+f]) do_ref(f);
      do_tick();
      for (int f = 0; f < F; f++) begin read_bit(f, b); chk("R5 tick clears", b, 0); end
      scan_expect("R4 R7 vector", int'(VEC[i][4:3]), int'(VEC[i][2:0]));
    end

    // R7 result held across ticks and references
    do_ref(0); do_tick();
    chk("R7 held frame", int'(victim_frame), 1);
    chk("R7 held age", int'(victim_age), 4);
    // ages now 7,2,2,2 with no flags; restore known state via ticks
    do_tick(); do_tick(); do_tick();
    // all ages zero now
    scan_expect("R4 decay to zero", 0, 0);

    // R5 reference in the same cycle as a tick is kept
    do_ref(0); do_ref(1); do_ref(2); do_tick();       // ages 4,4,4,0
    ref_valid = 1; ref_frame = 3; age_tick = 1; cyc();
    ref_valid = 0; age_tick = 0;                        // ages 2,2,2,0 flag3=1
    read_bit(3, b); chk("R5 ref kept on tick", b, 1);
    do_tick();                                           // ages 1,1,1,4
    scan_expect("R5 ref kept reaches age", 0, 1);

    // R5 clear in the same cycle as a tick: age still takes old flag
    do_ref(0);
    clr_valid = 1; clr_frame = 0; age_tick = 1; cyc();
    clr_valid = 0; age_tick = 0;                         // ages 4,0,0,2
    read_bit(0, b); chk("R5 clear with tick", b, 0);
    for (int k = 0; k < 2; k++) begin
      do_ref(1); do_ref(2); do_ref(3); do_tick();
    end                                                  // ages 1,6,6,6
    scan_expect("R5 clear with tick keeps age", 0, 1);

    // R8 start while busy ignored
    scan_start = 1; cyc(); c = 1;
    scan_start = 0; cyc(); c++;
    scan_start = 1; cyc(); c++;
    scan_start = 0;
    while (!scan_done && c < 50) begin cyc(); c++; end
    chk("R8 length unchanged", c, F + 1);
    cyc();
    chk("R8 no second search busy", int'(scan_busy), 0);
    repeat (F + 2) begin
      cyc();
      chk("R8 no second done", int'(scan_done), 0);
    end

    // R1 reset after activity
    do_ref(2); do_tick(); do_ref(1);
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    chk("R1 reset victim", int'(victim_frame), 0);
    for (int f = 0; f < F; f++) begin read_bit(f, b); chk("R1 flag after reset", b, 0); end
    scan_expect("R1 ages after reset", 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule